// File: doc/BRIEF.md
# SAR ADC Conversion Timing Sequencer

This block is the digital control for a single successive-approximation conversion. A one-cycle start request carries a channel number and a 2-bit final-sample-time code. The block takes the request only when it is idle and holds the channel and code on its outputs for the whole conversion. It then runs three phases, all counted in conversion-clock ticks. The first is a fixed two-tick buffered sample, with the amplifier enabled. The second is a directly coupled sample whose length the code selects. The third is a ten-tick resolution that tries one bit per tick, from the MSB down to the LSB.

The analog multiplexer, amplifier, capacitor array and comparator are not part of this block. It controls them through enable outputs, a channel number and a trial DAC code, and it reads back a single comparator bit. When the last bit is settled, the block emits a one-clock end-of-conversion pulse. The 10-bit result stays on its output until the next conversion finishes.

Top module: `sar_conv_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `amp_en`, `samp_en` and `eoc` are 0, and `dac_code`, `result`, `chan` and `st_code` are 0.
- R2: A `start` is accepted only on a clock edge where the block is idle (`busy` low). `start_ch` and `start_st` are latched at acceptance and appear on `chan` and `st_code` from the next cycle. They stay there until the next acceptance. A `start` while busy has no effect.
- R3: The buffered sample phase begins in the cycle after acceptance and lasts exactly 2 ticks. In this phase `amp_en` and `samp_en` are both 1.
- R4: The direct sample phase follows. In it `amp_en` is 0 and `samp_en` is 1. It lasts 2, 4, 8 or 16 ticks for `st_code` 0, 1, 2 and 3.
- R5: The resolution phase lasts 10 ticks and takes one bit per tick, bit 9 first. `dac_code` is the bits already kept, OR the current trial bit. At a tick, the trial bit is kept if `comp_ge` is 1 and dropped if it is 0.
- R6: `eoc` is high for exactly one clock, in the cycle after the tenth resolution tick. In that same cycle `result` shows the resolved code, and `result` changes in no other cycle.
- R7: `busy` is 1 from the cycle after acceptance up to the last resolution cycle. It is 0 in the `eoc` cycle.
- R8: Phases advance only at clock edges where `tick` is 1. A conversion therefore spans 14, 16, 20 or 28 ticks for codes 0 to 3.
- R9: `dac_code` is 0 outside the resolution phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Conversion clock enable |
| start | input | 1 | Conversion request |
| start_ch | input | CH_W | Channel for the request |
| start_st | input | 2 | Final-sample-time code for the request |
| comp_ge | input | 1 | Comparator: sampled voltage >= dac_code |
| busy | output | 1 | Conversion in progress |
| amp_en | output | 1 | Buffer amplifier in the sampling path |
| samp_en | output | 1 | Sample capacitor connected to the input |
| chan | output | CH_W | Latched channel number |
| st_code | output | 2 | Latched final-sample-time code |
| dac_code | output | RES_BITS | Trial code for the comparator DAC |
| eoc | output | 1 | End-of-conversion pulse |
| result | output | RES_BITS | Last conversion result |

## Verification
The bench runs all four sample-time codes at full tick rate, at one tick in three, and with irregular ticks. This exposes a phase counter that counts clocks instead of ticks, or that is off by one tick in any phase. The input voltages include 0, full scale, mid-scale, and alternating bit patterns. A design that resolves in the wrong bit order, or keeps a bit on the wrong comparator polarity, would produce a wrong `dac_code` sequence or a wrong `result`. The bench also raises `start` with a different channel in mid-conversion and again in the same cycle as `eoc`. A design that accepts requests while busy would corrupt `chan`, and one that stays busy one cycle too long would miss the back-to-back start.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_BUFFER  = 2'd1,
    PH_DIRECT  = 2'd2,
    PH_RESOLVE = 2'd3
  } phase_t;
endpackage

// File: rtl/sar_req_latch.sv
module sar_req_latch #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic [CH_W-1:0] req_ch,
  input  logic [1:0]      req_st,
  output logic [CH_W-1:0] held_ch,
  output logic [1:0]      held_st
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_ch <= '0;
      held_st <= '0;
    end else if (accept) begin
      held_ch <= req_ch;
      held_st <= req_st;
    end
  end
endmodule

// File: rtl/sar_phase_ctl.sv
module sar_phase_ctl
  import sar_seq_pkg::*;
#(
  parameter int INIT_TICKS    = 2,
  parameter int FS_BASE_LOG2  = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   accept,
  input  logic [1:0] st_code,
  input  logic   last_trial,
  output phase_t phase,
  output logic   load_sar
);
  localparam int FS_MAX   = 1 << (FS_BASE_LOG2 + 3);
  localparam int CNT_SPAN = (FS_MAX > INIT_TICKS) ? FS_MAX : INIT_TICKS;
  localparam int CNT_W    = $clog2(CNT_SPAN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] init_last;
  logic [CNT_W-1:0] fin_last;

  assign init_last = CNT_W'(INIT_TICKS - 1);
  assign fin_last  = CNT_W'((1 << (FS_BASE_LOG2 + int'(st_code))) - 1);
  assign load_sar  = (phase == PH_DIRECT) && tick && (cnt_q == fin_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt_q <= '0;
          if (accept) phase <= PH_BUFFER;
        end
        PH_BUFFER: if (tick) begin
          if (cnt_q == init_last) begin
            phase <= PH_DIRECT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DIRECT: if (tick) begin
          if (load_sar) begin
            phase <= PH_RESOLVE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_RESOLVE: if (tick && last_trial) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  phase_t              phase,
  input  logic                load_sar,
  input  logic                comp_ge,
  output logic                last_trial,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] result,
  output logic                eoc
);
  localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] kept_q;
  logic [RES_BITS-1:0] trial_q;
  logic [RES_BITS-1:0] kept_nx;
  logic                stepping;

  assign stepping   = (phase == PH_RESOLVE) && tick;
  assign last_trial = trial_q[0];
  assign kept_nx    = comp_ge ? (kept_q | trial_q) : kept_q;
  assign dac_code   = (phase == PH_RESOLVE) ? (kept_q | trial_q) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      kept_q  <= '0;
      trial_q <= '0;
      result  <= '0;
      eoc     <= 1'b0;
    end else begin
      eoc <= 1'b0;
      if (load_sar) begin
        kept_q  <= '0;
        trial_q <= MSB_ONLY;
      end else if (stepping) begin
        kept_q  <= kept_nx;
        trial_q <= trial_q >> 1;
        if (trial_q[0]) begin
          result <= kept_nx;
          eoc    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int CH_W         = 3,
  parameter int RES_BITS     = 10,
  parameter int INIT_TICKS   = 2,
  parameter int FS_BASE_LOG2 = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                start,
  input  logic [CH_W-1:0]     start_ch,
  input  logic [1:0]          start_st,
  input  logic                comp_ge,
  output logic                busy,
  output logic                amp_en,
  output logic                samp_en,
  output logic [CH_W-1:0]     chan,
  output logic [1:0]          st_code,
  output logic [RES_BITS-1:0] dac_code,
  output logic                eoc,
  output logic [RES_BITS-1:0] result
);
  phase_t phase;
  logic   accept;
  logic   load_sar;
  logic   last_trial;

  assign accept  = start && (phase == PH_IDLE);
  assign busy    = (phase != PH_IDLE);
  assign amp_en  = (phase == PH_BUFFER);
  assign samp_en = (phase == PH_BUFFER) || (phase == PH_DIRECT);

  sar_req_latch #(.CH_W(CH_W)) u_req (
    .clk(clk), .rst(rst), .accept(accept),
    .req_ch(start_ch), .req_st(start_st),
    .held_ch(chan), .held_st(st_code)
  );

  sar_phase_ctl #(.INIT_TICKS(INIT_TICKS), .FS_BASE_LOG2(FS_BASE_LOG2)) u_ctl (
    .clk(clk), .rst(rst), .tick(tick), .accept(accept),
    .st_code(st_code), .last_trial(last_trial),
    .phase(phase), .load_sar(load_sar)
  );

  sar_bit_engine #(.RES_BITS(RES_BITS)) u_sar (
    .clk(clk), .rst(rst), .tick(tick), .phase(phase),
    .load_sar(load_sar), .comp_ge(comp_ge),
    .last_trial(last_trial), .dac_code(dac_code),
    .result(result), .eoc(eoc)
  );
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int CH_W     = 3,
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                busy,
  input logic                amp_en,
  input logic                samp_en,
  input logic [CH_W-1:0]     chan,
  input logic [1:0]          st_code,
  input logic [RES_BITS-1:0] dac_code,
  input logic                eoc,
  input logic [RES_BITS-1:0] result
);
  a_r3_amp_in_sample: assert property (@(posedge clk) disable iff (rst)
    amp_en |-> samp_en);

  a_r6_eoc_single: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc);

  a_r6_result_moves_on_eoc: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> eoc);

  a_r7_idle_at_eoc: assert property (@(posedge clk) disable iff (rst)
    eoc |-> !busy);

  a_r7_busy_ends_with_eoc: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> eoc);

  a_r2_request_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(chan) && $stable(st_code)));

  a_r8_no_tick_no_move: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> (busy && $stable(amp_en) && $stable(samp_en) && $stable(dac_code)));

  a_r9_dac_quiet_when_sampling: assert property (@(posedge clk) disable iff (rst)
    samp_en |-> (dac_code == '0));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.CH_W(CH_W), .RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .busy(busy), .amp_en(amp_en),
  .samp_en(samp_en), .chan(chan), .st_code(st_code), .dac_code(dac_code),
  .eoc(eoc), .result(result)
);

// File: tb/sar_conv_seq_test.sv
`timescale 1ns/1ps
module sar_conv_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       start = 1'b0;
  logic [2:0] start_ch = '0;
  logic [1:0] start_st = '0;
  logic       comp_ge;
  logic       busy, amp_en, samp_en, eoc;
  logic [2:0] chan;
  logic [1:0] st_code;
  logic [9:0] dac_code, result;

  int checks = 0;
  int errors = 0;
  int vin = 0;
  int tick_mode = 0;
  int cyc = 0;
  bit started = 0;

  // reference model state
  int m_phase = 0, m_left = 0, m_bit = 0, m_acc = 0, m_res = 0;
  int m_ch = 0, m_st = 0, m_ticks = 0;
  bit m_eoc = 0;

  always #2.5 clk = ~clk;

  assign comp_ge = (vin >= int'(dac_code));

  sar_conv_seq uut (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .start_ch(start_ch),
    .start_st(start_st), .comp_ge(comp_ge), .busy(busy), .amp_en(amp_en),
    .samp_en(samp_en), .chan(chan), .st_code(st_code), .dac_code(dac_code),
    .eoc(eoc), .result(result)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    started = 1;
    m_eoc = 0;
    if (rst) begin
      m_phase = 0; m_acc = 0; m_res = 0; m_ch = 0; m_st = 0; m_ticks = 0;
    end else begin
      if (m_phase != 0 && tick) m_ticks++;
      case (m_phase)
        0: if (start) begin
             m_phase = 1; m_left = 2; m_ch = start_ch; m_st = start_st; m_ticks = 0;
           end
        1: if (tick) begin
             m_left--;
             if (m_left == 0) begin m_phase = 2; m_left = 2 << m_st; end
           end
        2: if (tick) begin
             m_left--;
             if (m_left == 0) begin m_phase = 3; m_bit = 9; m_acc = 0; end
           end
        default: if (tick) begin
             if (vin >= (m_acc | (1 << m_bit))) m_acc = m_acc | (1 << m_bit);
             if (m_bit == 0) begin
               m_res = m_acc; m_eoc = 1; m_phase = 0;
               chk("R8 conversion tick count", m_ticks, 12 + (2 << m_st));
             end else m_bit--;
           end
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk("R7 busy", busy, m_phase != 0);
      chk("R3 amp_en", amp_en, m_phase == 1);
      chk("R4 samp_en", samp_en, m_phase == 1 || m_phase == 2);
      chk("R5 R9 dac_code", dac_code, (m_phase == 3) ? (m_acc | (1 << m_bit)) : 0);
      chk("R6 eoc", eoc, m_eoc);
      chk("R6 result", result, m_res);
      chk("R2 chan", chan, m_ch);
      chk("R2 st_code", st_code, m_st);
    end
  end

  // tick generator
  always @(negedge clk) begin
    case (tick_mode)
      0: tick <= 1'b1;
      1: tick <= (cyc % 3 == 0);
      default: tick <= 1'($urandom_range(0, 1));
    endcase
  end

  task automatic conv(input int ch, input int st, input int v, input bit poke);
    int guard = 0;
    while (busy) @(negedge clk);
    vin = v;
    start <= 1'b1; start_ch <= 3'(ch); start_st <= 2'(st);
    @(negedge clk);
    start <= 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start <= 1'b1; start_ch <= 3'(ch ^ 7); start_st <= 2'(st ^ 3);  // R2 ignored while busy
      @(negedge clk);
      start <= 1'b0;
    end
    while (!eoc && guard < 2000) begin @(negedge clk); guard++; end
    chk("R6 result value", result, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset result", result, 0);
    rst <= 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {busy, amp_en, samp_en, eoc}, 0);
    chk("R1 dac after reset", dac_code, 0);
    for (int m = 0; m < 3; m++) begin
      tick_mode = m;
      conv(1, 0, 0, 0);
      conv(2, 1, 1023, 1);
      conv(5, 2, 512, 0);
      conv(6, 3, 341, 1);
      conv(7, 0, 682, 0);
      conv(3, 3, 1, 0);
    end
    // start raised in the eoc cycle is accepted (R7 idle there)
    tick_mode = 0;
    vin = 700;
    start <= 1'b1; start_ch <= 3'd4; start_st <= 2'd1;
    @(negedge clk);
    start <= 1'b0;
    while (!eoc) @(negedge clk);
    vin = 255;
    start <= 1'b1; start_ch <= 3'd2; start_st <= 2'd2;
    @(negedge clk);
    start <= 1'b0;
    chk("R7 back-to-back accepted", busy, 1);
    chk("R2 new channel", chan, 2);
    while (!eoc) @(negedge clk);
    chk("R6 back-to-back result", result, 255);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule